// File: doc/BRIEF.md
# Register-Move and ALU Opcode Decoder

This block turns one byte of the regular opcode quadrant of an 8-bit accumulator CPU into datapath controls. An opcode arrives with a valid strobe while the block is ready. The block latches it, splits it into a source field (bits 2:0), a destination or operation field (bits 5:3) and a class, and holds all of these steady until it pulses `done`. Opcodes outside the move and ALU ranges raise `other_op` so that neighbouring decode logic can take them.

A small register file with seven working registers is built in so that moves really take place. Operand code 6 does not name a register. It names the memory byte whose address is the H register (high byte) joined with the L register (low byte). When a move or ALU opcode reads that operand, the block raises a read request and takes one extra cycle to collect the data. When a move writes to it, the block issues a write request. The single opcode whose source and destination would both be the memory operand means halt instead. A preload and readback port lets the datapath fill and inspect the working registers while the block is idle.

Top module: `opdec_top`

## Requirements
- R1: After reset, `op_ready` is 1. `done`, `halt_req`, `other_op`, `alu_en`, `mem_rd` and `mem_wr` are 0, and every register reads back as 0.
- R2: Opcode 0x76 raises `halt_req` together with `done` in the cycle after it is accepted. It raises no memory request and no ALU enable, and it changes no register.
- R3: An opcode in 0x40..0x7F other than 0x76 is a move. `src_sel` equals bits 2:0 and `dst_sel` equals bits 5:3. After `done`, the destination register holds the source value and all other registers are unchanged.
- R4: An opcode in 0x80..0xBF is an ALU operation. In the `done` cycle, `alu_en` is 1, `alu_op` equals bits 5:3 (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP), and `alu_opnd` carries the source value. No register changes.
- R5: An opcode below 0x40 or at 0xC0 and above raises `other_op` with `done`. It raises no ALU enable and no memory request, and it leaves every register unchanged.
- R6: For a move or ALU opcode with source code 6, `mem_rd` is 1 in the cycle after acceptance, with `mem_addr` = {H, L} and `done` at 0. In the next cycle `done` is 1, `mem_rd` is 0, and `mem_rdata` is taken as the source value.
- R7: For a move with destination code 6, `mem_wr` and `done` are 1 together in the cycle after acceptance. In that cycle `mem_wdata` holds the source register value and `mem_addr` = {H, L}.
- R8: `op_ready` is 1 only when the block is idle. A `op_valid` seen while the block is busy is ignored. `src_sel`, `dst_sel` and `alu_op` stay stable from acceptance until `done`.
- R9: Register index encoding is 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A. Index 6 holds no register: a preload to index 6 is dropped and a readback of index 6 returns 0.
- R10: `done` is a one-cycle pulse, issued exactly once for each accepted opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_byte | input | 8 | Opcode |
| op_ready | output | 1 | Block idle, opcode can be accepted |
| src_sel | output | 3 | Source operand code |
| dst_sel | output | 3 | Destination operand code |
| alu_op | output | 3 | ALU operation code |
| alu_en | output | 1 | ALU operation valid (done cycle) |
| alu_opnd | output | 8 | ALU source operand value |
| halt_req | output | 1 | Halt request |
| other_op | output | 1 | Opcode outside this quadrant |
| done | output | 1 | Opcode completed |
| mem_rd | output | 1 | Memory operand read request |
| mem_wr | output | 1 | Memory operand write request |
| mem_addr | output | 16 | Memory operand address {H, L} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| rf_wr_en | input | 1 | Register preload enable (idle only) |
| rf_wr_idx | input | 3 | Register preload index |
| rf_wr_data | input | 8 | Register preload data |
| rf_rd_idx | input | 3 | Register readback index |
| rf_rd_data | output | 8 | Register readback data |

## Verification
The assertions check, on every cycle, the following:
- `done` lasts one cycle.
- A read request is followed by `done` one cycle later.
- Halt, hand-off and write strobes exclude the conflicting controls.
- The selects stay frozen while the block is busy.

Only the bench scenarios can show the data side. These cover the following:
- The right register receives the right value.
- The memory address is formed from H and L.
- The ALU operand is correct.
- Ignored strobes and the dropped preload leave every register intact.

// File: rtl/opdec_pkg.sv
`timescale 1ns/1ps
package opdec_pkg;
  typedef enum logic [1:0] {K_OTHER, K_HALT, K_MOVE, K_ALU} op_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT} seq_e;

  localparam logic [2:0] IDX_MEM  = 3'd6;
  localparam logic [7:0] OP_HALT  = 8'h76;

  function automatic op_kind_e kind_of(input logic [7:0] op);
    if (op == OP_HALT)          return K_HALT;
    else if (op[7:6] == 2'b01)  return K_MOVE;
    else if (op[7:6] == 2'b10)  return K_ALU;
    else                        return K_OTHER;
  endfunction

  function automatic logic [2:0] src_field(input logic [7:0] op);
    return op[2:0];
  endfunction

  function automatic logic [2:0] mid_field(input logic [7:0] op);
    return op[5:3];
  endfunction
endpackage

// File: rtl/opdec_decode.sv
`timescale 1ns/1ps
module opdec_decode
  import opdec_pkg::*;
(
  input  logic [7:0] op,
  output op_kind_e   kind,
  output logic [2:0] src,
  output logic [2:0] mid,
  output logic       src_mem,
  output logic       dst_mem
);
  always_comb begin
    kind    = kind_of(op);
    src     = src_field(op);
    mid     = mid_field(op);
    src_mem = (kind == K_MOVE || kind == K_ALU) && (src == IDX_MEM);
    dst_mem = (kind == K_MOVE) && (mid == IDX_MEM);
  end
endmodule

// File: rtl/opdec_seq.sv
`timescale 1ns/1ps
module opdec_seq
  import opdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic needs_rd,
  output logic accept,
  output logic idle,
  output logic exec_st,
  output logic wait_st
);
  seq_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (op_valid) st_nx = S_EXEC;
      S_EXEC:  st_nx = needs_rd ? S_WAIT : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;

  assign idle    = (st == S_IDLE);
  assign exec_st = (st == S_EXEC);
  assign wait_st = (st == S_WAIT);
  assign accept  = idle && op_valid;
endmodule

// File: rtl/opdec_regfile.sv
`timescale 1ns/1ps
module opdec_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int HOLE = 6,
  parameter int HI_I = 4,
  parameter int LO_I = 5,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] lo
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == HOLE) begin : g_hole
      assign regs[i] = '0;
    end else begin : g_ff
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                     regs[i] <= '0;
        else if (we && widx == IW'(i))  regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];
  assign hi      = regs[HI_I];
  assign lo      = regs[LO_I];
endmodule

// File: rtl/opdec_top.sv
`timescale 1ns/1ps
module opdec_top
  import opdec_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_byte,
  output logic          op_ready,
  output logic [2:0]    src_sel,
  output logic [2:0]    dst_sel,
  output logic [2:0]    alu_op,
  output logic          alu_en,
  output logic [DW-1:0] alu_opnd,
  output logic          halt_req,
  output logic          other_op,
  output logic          done,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rf_wr_en,
  input  logic [2:0]    rf_wr_idx,
  input  logic [DW-1:0] rf_wr_data,
  input  logic [2:0]    rf_rd_idx,
  output logic [DW-1:0] rf_rd_data
);
  logic [7:0]    op_q;
  op_kind_e      kind;
  logic [2:0]    src, mid;
  logic          src_mem, dst_mem;
  logic          accept, idle, exec_st, wait_st;
  logic          needs_rd;
  logic          ex_we, rf_we;
  logic [2:0]    rf_widx;
  logic [DW-1:0] rf_wdata, reg_src, src_val, h_q, l_q;

  opdec_decode u_dec (
    .op(op_q), .kind(kind), .src(src), .mid(mid),
    .src_mem(src_mem), .dst_mem(dst_mem)
  );

  assign needs_rd = src_mem;

  opdec_seq u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .needs_rd(needs_rd),
    .accept(accept), .idle(idle), .exec_st(exec_st), .wait_st(wait_st)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      op_q <= '0;
    else if (accept) op_q <= op_byte;

  assign src_val  = wait_st ? mem_rdata : reg_src;
  assign done     = (exec_st && !needs_rd) || wait_st;
  assign ex_we    = done && (kind == K_MOVE) && !dst_mem;
  assign rf_we    = ex_we || (rf_wr_en && idle);
  assign rf_widx  = ex_we ? mid : rf_wr_idx;
  assign rf_wdata = ex_we ? src_val : rf_wr_data;

  opdec_regfile #(.DW(DW), .NREG(8)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ridx_a(src), .rdata_a(reg_src), .ridx_b(rf_rd_idx), .rdata_b(rf_rd_data),
    .hi(h_q), .lo(l_q)
  );

  assign op_ready  = idle;
  assign src_sel   = src;
  assign dst_sel   = mid;
  assign alu_op    = mid;
  assign alu_en    = done && (kind == K_ALU);
  assign alu_opnd  = src_val;
  assign halt_req  = exec_st && (kind == K_HALT);
  assign other_op  = exec_st && (kind == K_OTHER);
  assign mem_rd    = exec_st && needs_rd;
  assign mem_wr    = exec_st && dst_mem;
  assign mem_addr  = {h_q, l_q};
  assign mem_wdata = reg_src;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (done && !mem_rd && !op_ready));
  // R2
  halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> (done && !mem_rd && !mem_wr && !alu_en && !other_op));
  // R5
  other_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    other_op |-> (done && !alu_en && !mem_rd && !mem_wr));
  // R7
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (done && !mem_rd && !alu_en));
  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready && !$past(op_ready)) |-> ($stable(src_sel) && $stable(dst_sel)));
  // R8
  ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_ready);
endmodule

// File: tb/sim_opdec_top.sv
`timescale 1ns/1ps
module sim_opdec_top;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0;
  logic [7:0]  op_byte = 0;
  logic        op_ready, alu_en, halt_req, other_op, done, mem_rd, mem_wr;
  logic [2:0]  src_sel, dst_sel, alu_op;
  logic [7:0]  alu_opnd, mem_wdata, rf_rd_data;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'hC3;
  logic        rf_wr_en = 0;
  logic [2:0]  rf_wr_idx = 0, rf_rd_idx = 0;
  logic [7:0]  rf_wr_data = 0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] model [8];

  localparam logic [7:0] MEMV = 8'hC3;
  // {kind, opcode}: kind 0 other, 1 halt, 2 move, 3 alu
  localparam logic [9:0] VEC [16] = '{
    {2'd2, 8'h78}, {2'd2, 8'h41}, {2'd2, 8'h5F}, {2'd2, 8'h7E},
    {2'd2, 8'h70}, {2'd1, 8'h76}, {2'd3, 8'h80}, {2'd3, 8'hAF},
    {2'd3, 8'hBE}, {2'd3, 8'h9A}, {2'd0, 8'h00}, {2'd0, 8'hC0},
    {2'd0, 8'h3F}, {2'd0, 8'hFF}, {2'd2, 8'h46}, {2'd2, 8'h6C}
  };

  opdec_top u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 8; i++) begin
      rf_rd_idx = 3'(i);
      #0.1;
      chk(rf_rd_data == model[i], tag, {8'(i), rf_rd_data}, {8'(i), model[i]});
    end
  endtask

  task automatic preload(input int idx, input logic [7:0] v);
    @(negedge clk);
    rf_wr_en = 1; rf_wr_idx = 3'(idx); rf_wr_data = v;
    @(negedge clk);
    rf_wr_en = 0;
    if (idx != 6) model[idx] = v;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [1:0] xk);
    logic [2:0] s, d;
    logic [7:0] sv;
    s = op[2:0]; d = op[5:3];
    @(negedge clk);
    op_byte = op; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    chk(src_sel == s && dst_sel == d && !op_ready, "R3 selects", {2'b0, src_sel, dst_sel}, {2'b0, s, d});
    sv = (s == 3'd6) ? MEMV : model[s];
    case (xk)
      2'd1: chk(halt_req && done && !mem_rd && !mem_wr && !alu_en, "R2 halt",
                {halt_req, done, mem_rd, mem_wr, alu_en}, 5'b11000);
      2'd0: chk(other_op && done && !alu_en && !mem_rd && !mem_wr && !halt_req, "R5 other",
                {other_op, done, alu_en, mem_rd, mem_wr}, 5'b11000);
      default: begin
        if (s == 3'd6) begin
          chk(mem_rd && !done && mem_addr == {model[4], model[5]}, "R6 read request",
              {mem_rd, done, mem_addr}, {2'b10, model[4], model[5]});
          @(negedge clk);
          chk(done && !mem_rd && alu_opnd == MEMV, "R6 read data", {done, mem_rd, alu_opnd}, {2'b10, MEMV});
        end
        if (xk == 2'd2) begin
          if (d == 3'd6)
            chk(mem_wr && done && mem_wdata == sv && mem_addr == {model[4], model[5]}, "R7 mem write",
                {mem_wr, done, mem_wdata}, {2'b11, sv});
          else begin
            chk(done && !mem_wr && !alu_en, "R3 move done", {done, mem_wr, alu_en}, 3'b100);
            model[d] = sv;
          end
        end else
          chk(alu_en && done && alu_op == d && alu_opnd == sv, "R4 alu",
              {alu_en, done, alu_op, alu_opnd}, {2'b11, d, sv});
      end
    endcase
    @(negedge clk);
    chk(op_ready && !done, "R10 single done", {op_ready, done}, 2'b10);
    check_regs(xk == 2'd2 ? "R3 regs" : (xk == 2'd3 ? "R4 regs" : "R5 regs"));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    #12 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(op_ready && !done && !halt_req && !other_op && !alu_en && !mem_rd && !mem_wr, "R1 reset",
        {op_ready, done, halt_req, other_op, alu_en, mem_rd, mem_wr}, 7'b1000000);
    check_regs("R1 regs");
    preload(0, 8'h11); preload(1, 8'h22); preload(2, 8'h33); preload(3, 8'h44);
    preload(4, 8'h12); preload(5, 8'h34); preload(7, 8'h77);
    check_regs("R9 preload");
    for (int v = 0; v < 16; v++) run_op(VEC[v][7:0], VEC[v][9:8]);

    // R9 index 6 holds nothing
    preload(6, 8'hEE);
    check_regs("R9 hole");

    // R8 strobe while busy is ignored, selects stay stable
    @(negedge clk);
    op_byte = 8'h7E; op_valid = 1;
    @(negedge clk);
    op_byte = 8'h41;
    chk(!op_ready && src_sel == 3'd6 && dst_sel == 3'd7, "R8 busy exec", {op_ready, src_sel, dst_sel}, 7'b0110111);
    @(negedge clk);
    chk(!op_ready && done && src_sel == 3'd6 && dst_sel == 3'd7, "R8 busy wait",
        {op_ready, done, src_sel, dst_sel}, 8'b01110111);
    op_valid = 0;
    model[7] = MEMV;
    @(negedge clk);
    chk(op_ready && !done, "R10 no extra done", {op_ready, done}, 2'b10);
    check_regs("R8 ignored strobe");

    // R8 preload while busy is dropped
    @(negedge clk);
    op_byte = 8'h00; op_valid = 1;
    @(negedge clk);
    op_valid = 0; rf_wr_en = 1; rf_wr_idx = 3'd0; rf_wr_data = 8'h99;
    @(negedge clk);
    rf_wr_en = 0;
    check_regs("R8 busy preload");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule